// File: doc/BRIEF.md
# Comparator Timer Channel with Periodic Reload

This block holds one timer channel together with the 64-bit main counter it watches. The counter advances by one per clock while the global run input is high and holds its value while it is low. It can be loaded directly at any time. The channel keeps a comparator and a period register. When the counter reaches the comparator it emits a one-clock fire pulse. The match test uses the signed difference of comparator minus counter, so a comparator that is already behind the counter fires at once. In periodic mode every fire moves the comparator forward by the period, one addition per clock, until the comparator is ahead of the counter again.

A narrow mode limits the comparator, the written data and the comparison to the low 32 bits, and the periodic sums wrap at 2^32. One comparator write port serves both registers. In one-shot mode a write goes to the comparator. In periodic mode it goes to the period, unless a one-time "load comparator" flag has been raised first. Every write to the port clears that flag.

Top module: `cmp_timer_channel`

## Requirements
- R1: While reset is high, the registers settle to: counter 0, comparator all ones, period 0, load-comparator flag 0, fire 0.
- R2: Counter update: with `run` high the counter increases by 1 per clock. With `run` low it holds. A clock with `cnt_wr` high loads `cnt_wr_data` instead.
- R3: A write on `cmp_wr` goes to the comparator when `periodic` is 0 or the load-comparator flag is 1. It goes to the period register when `periodic` is 1 and the flag is 0, and the comparator is left unchanged.
- R4: A clock with `cmp_load_req` high sets the load-comparator flag. Any clock with `cmp_wr` high clears it.
- R5: With `narrow` high, written data keeps only bits 31:0. Within one clock the stored comparator also loses its upper 32 bits.
- R6: `fire` is a one-clock pulse. It goes high on the clock edge after the edge at which the counter output first satisfies signed(comparator − counter) ≤ 0. Only bits 31:0 take part when `narrow` is high.
- R7: A comparator write with a value at or behind the counter makes `fire` high two clock edges later.
- R8: `fire` is never high unless `run` and `ch_en` were both 1 at the edge that raised it. A channel with a comparator behind the counter fires at the first edge where both are 1.
- R9: In one-shot mode, after a fire there is no further fire until the comparator is written, the channel is re-enabled, or the comparator is again ahead of the counter.
- R10: In periodic mode with a nonzero period, the edge that raises `fire` also adds the period to the comparator. While the comparator stays at or behind the counter, one more addition follows each clock, with no fire, until the comparator is ahead.
- R11: In narrow mode each periodic addition wraps modulo 2^32.
- R12: In periodic mode with period 0, a fire leaves the comparator unchanged and no repeat fire follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Global enable: counter runs and channel may fire |
| ch_en | input | 1 | Channel enable |
| periodic | input | 1 | 1 = periodic mode, 0 = one-shot |
| narrow | input | 1 | 1 = 32-bit comparator mode |
| cmp_load_req | input | 1 | Raises the load-comparator flag |
| cnt_wr | input | 1 | Counter load strobe |
| cnt_wr_data | input | 64 | Counter load value |
| cmp_wr | input | 1 | Comparator/period write strobe |
| cmp_wr_data | input | 64 | Comparator/period write value |
| cnt_value | output | 64 | Main counter |
| cmp_value | output | 64 | Comparator read-back |
| period_value | output | 64 | Period read-back |
| cmp_load_flag | output | 1 | Load-comparator flag state |
| fire | output | 1 | Match pulse |

## Verification
The assertions check on every cycle that the counter increments or holds, that writes are routed correctly and clear the flag, that narrow mode clears the comparator's upper half, and that `fire` is a single-cycle pulse gated by both enables. A period of zero must leave the comparator untouched after a fire. Only the bench scenarios can show that fires land on the exact counter value expected. They also show the catch-up sequence after the counter has jumped far past the comparator, the 2^32 wrap of a periodic sum, and the silence of a one-shot channel after its match.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int CNT_W_DEF    = 64;
  localparam int NARROW_W_DEF = 32;

  typedef enum logic [1:0] {
    RT_NONE   = 2'd0,
    RT_CMP    = 2'd1,
    RT_PERIOD = 2'd2
  } wr_route_e;
endpackage

// File: rtl/tmr_main_counter.sv
`timescale 1ns/1ps
module tmr_main_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (ld)  cnt <= ld_val;
    else if (run) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/tmr_reach_detect.sv
`timescale 1ns/1ps
module tmr_reach_detect #(
  parameter int W  = 64,
  parameter int NW = 32
) (
  input  logic         narrow,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  output logic         reached
);
  logic [W-1:0] gap;
  logic         wide_hit;
  assign gap      = cmp - cnt;
  assign wide_hit = gap[W-1] || (gap == '0);

  generate
    if (NW < W) begin : g_dual
      logic narrow_hit;
      assign narrow_hit = gap[NW-1] || (gap[NW-1:0] == '0);
      assign reached    = narrow ? narrow_hit : wide_hit;
    end else begin : g_wide_only
      logic unused_narrow;
      assign unused_narrow = narrow;
      assign reached       = wide_hit;
    end
  endgenerate
endmodule

// File: rtl/tmr_cmp_regs.sv
`timescale 1ns/1ps
module tmr_cmp_regs
  import tmr_pkg::*;
#(
  parameter int W  = 64,
  parameter int NW = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         periodic,
  input  logic         narrow,
  input  logic         load_req,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic         adv,
  output logic [W-1:0] cmp,
  output logic [W-1:0] period,
  output logic         load_flag
);
  localparam logic [W-1:0] LOW_MASK = {{(W-NW){1'b0}}, {NW{1'b1}}};

  logic [W-1:0] keep_mask;
  wr_route_e    route;

  assign keep_mask = narrow ? LOW_MASK : '1;

  always_comb begin
    route = RT_NONE;
    if (wr) route = (!periodic || load_flag) ? RT_CMP : RT_PERIOD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp       <= '1;
      period    <= '0;
      load_flag <= 1'b0;
    end else begin
      unique case (route)
        RT_CMP:    cmp    <= wr_data & keep_mask;
        RT_PERIOD: period <= wr_data & keep_mask;
        default: begin
          if (adv) cmp <= (cmp + period) & keep_mask;
          else     cmp <= cmp & keep_mask;
        end
      endcase
      if (wr)            load_flag <= 1'b0;
      else if (load_req) load_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr_fire_ctrl.sv
`timescale 1ns/1ps
module tmr_fire_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic reached,
  input  logic wr,
  input  logic periodic,
  input  logic period_nz,
  output logic adv,
  output logic fire
);
  logic armed;
  logic active_q;
  logic hit;
  logic reload_ok;

  assign hit       = active && armed && reached && !wr;
  assign reload_ok = periodic && period_nz && active && !wr;
  assign adv       = reload_ok && reached && (hit || !armed);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b1;
      active_q <= 1'b0;
      fire     <= 1'b0;
    end else begin
      active_q <= active;
      fire     <= hit;
      if (wr)                     armed <= 1'b1;
      else if (hit)               armed <= 1'b0;
      else if (active && !active_q) armed <= 1'b1;
      else if (!reached)          armed <= 1'b1;
    end
  end
endmodule

// File: rtl/cmp_timer_channel.sv
`timescale 1ns/1ps
module cmp_timer_channel #(
  parameter int CNT_W    = tmr_pkg::CNT_W_DEF,
  parameter int NARROW_W = tmr_pkg::NARROW_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             ch_en,
  input  logic             periodic,
  input  logic             narrow,
  input  logic             cmp_load_req,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wr_data,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wr_data,
  output logic [CNT_W-1:0] cnt_value,
  output logic [CNT_W-1:0] cmp_value,
  output logic [CNT_W-1:0] period_value,
  output logic             cmp_load_flag,
  output logic             fire
);
  logic reached;
  logic adv;
  logic active;
  logic period_nz;

  assign active    = run && ch_en;
  assign period_nz = (period_value != '0);

  tmr_main_counter #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .ld     (cnt_wr),
    .ld_val (cnt_wr_data),
    .cnt    (cnt_value)
  );

  tmr_reach_detect #(.W(CNT_W), .NW(NARROW_W)) u_reach (
    .narrow  (narrow),
    .cnt     (cnt_value),
    .cmp     (cmp_value),
    .reached (reached)
  );

  tmr_cmp_regs #(.W(CNT_W), .NW(NARROW_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .periodic  (periodic),
    .narrow    (narrow),
    .load_req  (cmp_load_req),
    .wr        (cmp_wr),
    .wr_data   (cmp_wr_data),
    .adv       (adv),
    .cmp       (cmp_value),
    .period    (period_value),
    .load_flag (cmp_load_flag)
  );

  tmr_fire_ctrl u_fire (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .reached   (reached),
    .wr        (cmp_wr),
    .periodic  (periodic),
    .period_nz (period_nz),
    .adv       (adv),
    .fire      (fire)
  );
endmodule

// File: rtl/cmp_timer_channel_chk.sv
`timescale 1ns/1ps
module cmp_timer_channel_chk #(
  parameter int CNT_W    = 64,
  parameter int NARROW_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             ch_en,
  input logic             periodic,
  input logic             narrow,
  input logic             cnt_wr,
  input logic             cmp_wr,
  input logic [CNT_W-1:0] cmp_wr_data,
  input logic [CNT_W-1:0] cnt_value,
  input logic [CNT_W-1:0] cmp_value,
  input logic [CNT_W-1:0] period_value,
  input logic             cmp_load_flag,
  input logic             fire
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (cnt_value == '0 && cmp_value == '1 && period_value == '0 &&
             !cmp_load_flag && !fire));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !cnt_wr) |=> (cnt_value == $past(cnt_value) + CNT_W'(1)));

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> $stable(cnt_value));

  // R3
  oneshot_route_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_wr && !periodic && !narrow) |=> (cmp_value == $past(cmp_wr_data)));

  // R3
  period_route_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_wr && periodic && !cmp_load_flag && !narrow) |=>
      (period_value == $past(cmp_wr_data) && $stable(cmp_value)));

  // R4
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_wr |=> !cmp_load_flag);

  // R5
  narrow_trunc_chk: assert property (@(posedge clk) disable iff (rst)
    (narrow && !cmp_wr) |=> (cmp_value[CNT_W-1:NARROW_W] == '0));

  // R6
  fire_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);

  // R8
  fire_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fire) |-> $past(run && ch_en));

  // R12
  zero_period_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && period_value == '0 && !cmp_wr && !narrow) |=> $stable(cmp_value));
endmodule

bind cmp_timer_channel cmp_timer_channel_chk #(
  .CNT_W(CNT_W), .NARROW_W(NARROW_W)
) u_chk (
  .clk(clk), .rst(rst), .run(run), .ch_en(ch_en), .periodic(periodic),
  .narrow(narrow), .cnt_wr(cnt_wr), .cmp_wr(cmp_wr), .cmp_wr_data(cmp_wr_data),
  .cnt_value(cnt_value), .cmp_value(cmp_value), .period_value(period_value),
  .cmp_load_flag(cmp_load_flag), .fire(fire)
);

// File: tb/cmp_timer_channel_tb.sv
`timescale 1ns/1ps
module cmp_timer_channel_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0, ch_en = 1'b0, periodic = 1'b0, narrow = 1'b0;
  logic        cmp_load_req = 1'b0, cnt_wr = 1'b0, cmp_wr = 1'b0;
  logic [63:0] cnt_wr_data = '0, cmp_wr_data = '0;
  logic [63:0] cnt_value, cmp_value, period_value;
  logic        cmp_load_flag, fire;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  logic [63:0] exp_q[$];

  always #2.5 clk = ~clk;

  cmp_timer_channel u_dut (
    .clk(clk), .rst(rst), .run(run), .ch_en(ch_en), .periodic(periodic),
    .narrow(narrow), .cmp_load_req(cmp_load_req), .cnt_wr(cnt_wr),
    .cnt_wr_data(cnt_wr_data), .cmp_wr(cmp_wr), .cmp_wr_data(cmp_wr_data),
    .cnt_value(cnt_value), .cmp_value(cmp_value), .period_value(period_value),
    .cmp_load_flag(cmp_load_flag), .fire(fire)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cmp(input logic [63:0] d);
    cmp_wr = 1'b1; cmp_wr_data = d; step(1); cmp_wr = 1'b0;
  endtask

  task automatic wr_cnt(input logic [63:0] d);
    cnt_wr = 1'b1; cnt_wr_data = d; step(1); cnt_wr = 1'b0;
  endtask

  task automatic raise_flag();
    cmp_load_req = 1'b1; step(1); cmp_load_req = 1'b0;
  endtask

  // scoreboard monitor: each fire must match the next expected counter value
  always @(negedge clk) begin
    if (!rst && fire) begin
      nchk++;
      if (exp_q.size() == 0) begin
        nfail++;
        $display("FAIL R9 unexpected fire: actual cnt %h expected no fire", cnt_value);
      end else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        if (cnt_value !== e) begin
          nfail++;
          $display("FAIL R6 fire position: actual cnt %h expected %h", cnt_value, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    step(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 cnt", cnt_value, 64'd0);
    chk("R1 cmp", cmp_value, '1);
    chk("R1 period", period_value, 64'd0);
    chk("R1 flag", {63'd0, cmp_load_flag}, 64'd0);
    chk("R1 fire", {63'd0, fire}, 64'd0);

    // R2 hold, load, count
    step(3);
    chk("R2 hold", cnt_value, 64'd0);
    wr_cnt(64'd100);
    chk("R2 load", cnt_value, 64'd100);
    run = 1'b1; step(5);
    chk("R2 count", cnt_value, 64'd105);
    run = 1'b0;

    // R5 stored comparator truncated when narrow goes high
    narrow = 1'b1; step(1);
    chk("R5 trunc stored", cmp_value, 64'h0000_0000_FFFF_FFFF);
    narrow = 1'b0;

    // R3 routing, R4 flag
    wr_cmp(64'h0000_5000_0000_0000);
    chk("R3 oneshot to cmp", cmp_value, 64'h0000_5000_0000_0000);
    periodic = 1'b1;
    wr_cmp(64'd77);
    chk("R3 periodic to period", period_value, 64'd77);
    chk("R3 cmp untouched", cmp_value, 64'h0000_5000_0000_0000);
    raise_flag();
    chk("R4 flag set", {63'd0, cmp_load_flag}, 64'd1);
    wr_cmp(64'h123);
    chk("R4 flag cleared", {63'd0, cmp_load_flag}, 64'd0);
    chk("R3 flag routes to cmp", cmp_value, 64'h123);
    chk("R3 period kept", period_value, 64'd77);

    // R5 write truncation
    narrow = 1'b1;
    raise_flag();
    wr_cmp(64'h1_0000_0456);
    chk("R5 cmp write narrow", cmp_value, 64'h456);
    wr_cmp(64'hABCD_0000_0009);
    chk("R5 period write narrow", period_value, 64'h9);
    narrow = 1'b0;

    // R8 gating: run without channel enable, comparator behind
    periodic = 1'b0;
    run = 1'b1;
    wr_cmp(64'd50);
    step(10);
    v = cnt_value;
    exp_q.push_back(v + 64'd1);
    ch_en = 1'b1;            // R8 fires at first enabled edge
    step(3);
    // R9 one-shot stays quiet
    step(20);
    v = cnt_value;
    exp_q.push_back(v + 64'd21);
    wr_cmp(v + 64'd20);
    step(30);
    // R7 immediate fire on write behind counter
    v = cnt_value;
    exp_q.push_back(v + 64'd2);
    wr_cmp(v - 64'd10);
    step(5);
    chk("R7 queue drained", 64'(exp_q.size()), 64'd0);

    // R10 periodic, 64-bit
    ch_en = 1'b0; periodic = 1'b1;
    wr_cmp(64'd25);
    chk("R3 period 25", period_value, 64'd25);
    raise_flag();
    v = cnt_value;
    exp_q.push_back(v + 64'd11);
    exp_q.push_back(v + 64'd36);
    exp_q.push_back(v + 64'd61);
    exp_q.push_back(v + 64'd86);
    wr_cmp(v + 64'd10);
    ch_en = 1'b1;
    step(94);
    ch_en = 1'b0;
    chk("R10 cmp after four fires", cmp_value, v + 64'd110);

    // R10 catch-up after counter jumped ahead
    run = 1'b0;
    wr_cnt(64'd1000);
    wr_cmp(64'd100);
    raise_flag();
    wr_cmp(64'd500);
    ch_en = 1'b1;
    step(1);
    exp_q.push_back(64'd1001);
    exp_q.push_back(64'd1101);
    run = 1'b1;
    step(8);
    chk("R10 catch-up result", cmp_value, 64'd1100);
    step(142);
    run = 1'b0; ch_en = 1'b0;
    chk("R10 after catch-up fire", cmp_value, 64'd1200);

    // R12 zero period
    wr_cnt(64'd2000);
    wr_cmp(64'd0);
    raise_flag();
    wr_cmp(64'd1990);
    ch_en = 1'b1;
    exp_q.push_back(64'd2001);
    run = 1'b1;
    step(20);
    chk("R12 cmp unchanged", cmp_value, 64'd1990);
    run = 1'b0; ch_en = 1'b0;

    // R11 narrow wrap
    narrow = 1'b1;
    wr_cnt(64'h1_FFFF_FFF0);
    wr_cmp(64'h20);
    raise_flag();
    wr_cmp(64'h1_FFFF_FFF8);
    chk("R5 narrow cmp", cmp_value, 64'hFFFF_FFF8);
    ch_en = 1'b1;
    exp_q.push_back(64'h1_FFFF_FFF9);
    exp_q.push_back(64'h2_0000_0019);
    run = 1'b1;
    step(50);
    chk("R11 wrapped cmp", cmp_value, 64'h38);
    run = 1'b0; ch_en = 1'b0; narrow = 1'b0;
    step(3);
    chk("R6 all expected fires seen", 64'(exp_q.size()), 64'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule